// File: doc/BRIEF.md
# Multi-Source Synchronized Reset Generator

This block produces one active-low reset for each of a set of clock domains, each reset released in step with that domain's own clock. Three things can put a domain into reset: a low level on the asynchronous chip reset pin, a reset request from the watchdog timer, and a per-domain software reset bit. Any of them pulls the domain's reset low at once, with no clock needed. The reset is let go only after two rising edges of that domain's clock, so every flop in the domain leaves reset on a clean edge.

The software reset bits sit in a small register in the control clock domain. Writing a one holds a domain in reset until software writes the bit back to zero. A watchdog request clears every software bit. The same register holds a read-only cause flag. The flag becomes 1 when a watchdog request is seen and stays 1 through the reset it causes. Only the pin reset clears it, so it reads 0 after a pin reset and 1 after a watchdog reset.

Top module: `mrst_hub`

## Requirements
- R1: While `pin_rst_n` is low, every bit of `mod_rst_n` is 0, the cause flag `wdt_cause` is 0 and all software reset bits are cleared, with no clock edge needed.
- R2: While `wdt_req` is 1, every bit of `mod_rst_n` is 0, without waiting for any clock edge.
- R3: A write (`sw_we` = 1 at a rising edge of `ctl_clk`) with bit i of `sw_wdata` at 1 drives `mod_rst_n[i]` to 0 right after that edge. Domains whose bit is 0 are not affected.
- R4: A software reset bit keeps its domain in reset until a later write stores 0 in that bit. While `sw_we` is 0, `sw_wdata` has no effect.
- R5: Once every source for domain i is inactive, `mod_rst_n[i]` stays 0 at the first rising edge of `mod_clk[i]` and becomes 1 at the second (SYNC_STAGES = 2).
- R6: `wdt_cause` becomes 1 at the first `ctl_clk` rising edge where `wdt_req` is 1, and then stays 1 until `pin_rst_n` goes low.
- R7: A `ctl_clk` edge with `wdt_req` at 1 clears every software reset bit, and a write in that same cycle is dropped.
- R8: Each domain's release is timed only by its own clock, so domains with different clock periods leave reset at different times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_clk | input | 1 | Control clock for the software reset bits and the cause flag |
| pin_rst_n | input | 1 | Asynchronous chip reset pin, active low |
| wdt_req | input | 1 | Watchdog reset request, active high, held for at least one `ctl_clk` cycle |
| sw_we | input | 1 | Write strobe for the software reset bits |
| sw_wdata | input | N_DOM | New software reset bits, bit i belongs to domain i |
| mod_clk | input | N_DOM | Domain clocks, bit i clocks domain i |
| mod_rst_n | output | N_DOM | Synchronized active-low resets, bit i for domain i |
| wdt_cause | output | 1 | Reset cause flag: 0 after a pin reset, 1 after a watchdog reset |

## Verification
Assertion of a reset has no latency, so the bench checks it one nanosecond after it changes the pin or watchdog input, before any domain clock edge. A software bit takes effect at the `ctl_clk` edge that captures the write, so it is checked on the next falling edge. Release is due on the second rising edge of each domain clock after the last source goes away. The bench keeps an edge count per domain, clears it whenever that domain's model source is active, and compares the model with the outputs after every control clock edge. Domain clock edges are placed at times that never meet a control edge or an input change, so each comparison sees settled values.

// File: rtl/mrst_pkg.sv
package mrst_pkg;

    // Smallest synchronizer that still gives a metastability-safe release
    localparam int unsigned MIN_SYNC = 2;

    // A domain is held in reset when any one of its three sources is active
    function automatic logic src_active(input logic pin_n,
                                        input logic wdt,
                                        input logic sw_bit);
        return (~pin_n) | wdt | sw_bit;
    endfunction

endpackage

// File: rtl/mrst_swreg.sv
module mrst_swreg #(
    parameter int unsigned N_DOM = 4
) (
    input  logic             ctl_clk,
    input  logic             pin_rst_n,
    input  logic             wdt_req,
    input  logic             sw_we,
    input  logic [N_DOM-1:0] sw_wdata,
    output logic [N_DOM-1:0] sw_bits,
    output logic             wdt_cause
);

    typedef struct packed {
        logic [N_DOM-1:0] sw;
        logic             cause;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wdt_req) begin
            // A watchdog reset wipes software holds and records its cause
            st_d.sw    = '0;
            st_d.cause = 1'b1;
        end else if (sw_we) begin
            st_d.sw = sw_wdata;
        end
    end

    always_ff @(posedge ctl_clk or negedge pin_rst_n) begin
        if (!pin_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_bits   = st_q.sw;
    assign wdt_cause = st_q.cause;

endmodule

// File: rtl/mrst_sync.sv
module mrst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic rst_n
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.chain = {sy_q.chain[STAGES-2:0], 1'b1};
    end

    // Assert at once on arst, release by shifting ones in on clk
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign rst_n = sy_q.chain[STAGES-1];

endmodule

// File: rtl/mrst_hub.sv
module mrst_hub #(
    parameter int unsigned N_DOM       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             ctl_clk,
    input  logic             pin_rst_n,
    input  logic             wdt_req,
    input  logic             sw_we,
    input  logic [N_DOM-1:0] sw_wdata,
    input  logic [N_DOM-1:0] mod_clk,
    output logic [N_DOM-1:0] mod_rst_n,
    output logic             wdt_cause
);
    import mrst_pkg::*;

    localparam int unsigned STAGES = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

    logic [N_DOM-1:0] sw_bits;
    logic [N_DOM-1:0] dom_arst;

    mrst_swreg #(.N_DOM(N_DOM)) u_swreg (
        .ctl_clk   (ctl_clk),
        .pin_rst_n (pin_rst_n),
        .wdt_req   (wdt_req),
        .sw_we     (sw_we),
        .sw_wdata  (sw_wdata),
        .sw_bits   (sw_bits),
        .wdt_cause (wdt_cause)
    );

    for (genvar i = 0; i < N_DOM; i++) begin : g_dom
        assign dom_arst[i] = src_active(pin_rst_n, wdt_req, sw_bits[i]);

        mrst_sync #(.STAGES(STAGES)) u_sync (
            .clk   (mod_clk[i]),
            .arst  (dom_arst[i]),
            .rst_n (mod_rst_n[i])
        );
    end

endmodule

// File: rtl/mrst_chk.sv
module mrst_chk #(
    parameter int unsigned N_DOM = 4
) (
    input logic             ctl_clk,
    input logic             pin_rst_n,
    input logic             wdt_req,
    input logic             sw_we,
    input logic [N_DOM-1:0] sw_wdata,
    input logic [N_DOM-1:0] mod_clk,
    input logic [N_DOM-1:0] mod_rst_n,
    input logic             wdt_cause,
    input logic [N_DOM-1:0] sw_bits,
    input logic [N_DOM-1:0] dom_arst
);

    always @(posedge ctl_clk) begin
        if (!pin_rst_n) begin
            AST_PIN_HOLDS_ALL: assert (mod_rst_n == '0 && !wdt_cause && sw_bits == '0); // R1
        end
    end

    AST_WDT_HOLDS_ALL: assert property (@(posedge ctl_clk) disable iff (!pin_rst_n)
        wdt_req |-> (mod_rst_n == '0)); // R2

    AST_SW_WRITE_ASSERTS: assert property (@(posedge ctl_clk) disable iff (!pin_rst_n)
        (sw_we && !wdt_req) |=> ((~mod_rst_n & $past(sw_wdata)) == $past(sw_wdata))); // R3

    AST_SW_BITS_KEPT: assert property (@(posedge ctl_clk) disable iff (!pin_rst_n)
        (!sw_we && !wdt_req) |=> $stable(sw_bits)); // R4

    AST_CAUSE_SET: assert property (@(posedge ctl_clk) disable iff (!pin_rst_n)
        wdt_req |=> wdt_cause); // R6

    AST_CAUSE_STICKY: assert property (@(posedge ctl_clk) disable iff (!pin_rst_n)
        wdt_cause |=> wdt_cause); // R6

    AST_WDT_CLEARS_SW: assert property (@(posedge ctl_clk) disable iff (!pin_rst_n)
        wdt_req |=> (sw_bits == '0)); // R7

    for (genvar i = 0; i < N_DOM; i++) begin : g_rel
        AST_RELEASE_TWO_EDGES: assert property (@(posedge mod_clk[i]) disable iff (!pin_rst_n)
            $rose(mod_rst_n[i]) |-> (!$past(dom_arst[i]) && !$past(dom_arst[i], 2))); // R5
    end

endmodule

bind mrst_hub mrst_chk #(.N_DOM(N_DOM)) u_chk (
    .ctl_clk   (ctl_clk),
    .pin_rst_n (pin_rst_n),
    .wdt_req   (wdt_req),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .mod_clk   (mod_clk),
    .mod_rst_n (mod_rst_n),
    .wdt_cause (wdt_cause),
    .sw_bits   (sw_bits),
    .dom_arst  (dom_arst)
);

// File: tb/sim_mrst_hub.sv
module sim_mrst_hub;
    localparam int ND = 3;

    logic          ctl_clk = 1'b0;
    logic          pin_n   = 1'b1;
    logic          wdt     = 1'b0;
    logic          we      = 1'b0;
    logic [ND-1:0] wdata   = '0;
    wire  [ND-1:0] mclk;
    wire  [ND-1:0] rst_n;
    wire           cause;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  checking = 1'b0;
    bit  done = 1'b0;
    string tag = "R1";

    // 250 MHz control clock: rising edges at 2, 6, 10 ns ...
    always #2 ctl_clk = ~ctl_clk;

    // Domain clocks: rising edges at 1 ns + k*4*(g+1) ns, never on a control edge
    for (genvar g = 0; g < ND; g++) begin : g_ck
        logic ck = 1'b0;
        initial begin
            #1;
            forever begin
                ck = 1'b1; #(2*(g+1));
                ck = 1'b0; #(2*(g+1));
            end
        end
        assign mclk[g] = ck;
    end

    mrst_hub #(.N_DOM(ND), .SYNC_STAGES(2)) u0 (
        .ctl_clk   (ctl_clk),
        .pin_rst_n (pin_n),
        .wdt_req   (wdt),
        .sw_we     (we),
        .sw_wdata  (wdata),
        .mod_clk   (mclk),
        .mod_rst_n (rst_n),
        .wdt_cause (cause)
    );

    // Behavioural reference model
    logic [ND-1:0] sw_m = '0;
    logic          cause_m = 1'b0;
    always @(posedge ctl_clk or negedge pin_n) begin
        if (!pin_n)     begin sw_m <= '0; cause_m <= 1'b0; end
        else if (wdt)   begin sw_m <= '0; cause_m <= 1'b1; end
        else if (we)    sw_m <= wdata;
    end
    wire [ND-1:0] src_m = {ND{~pin_n | wdt}} | sw_m;
    wire [ND-1:0] exp_n;

    for (genvar g = 0; g < ND; g++) begin : g_mdl
        int edges = 0;
        always @(posedge g_ck[g].ck or posedge src_m[g]) begin
            if (src_m[g])       edges = 0;
            else if (edges < 2) edges = edges + 1;
        end
        assign exp_n[g] = !src_m[g] && (edges >= 2);
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, expv, $time);
        end
    endtask

    // Compare model and outputs after every control clock edge
    always @(posedge ctl_clk) begin
        #1;
        if (checking && !done) begin
            chk(tag, 8'(rst_n), 8'(exp_n));
            chk("R6", 8'(cause), 8'(cause_m));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge ctl_clk);
    endtask

    task automatic sw_write(input logic [ND-1:0] v);
        @(negedge ctl_clk);
        we = 1'b1; wdata = v;
        @(negedge ctl_clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog timeout at %0t", $time);
        finish_run();
    end

    initial begin
        @(negedge ctl_clk);
        // R1: pin reset holds everything with no clock needed
        pin_n = 1'b0;
        #1;
        checking = 1'b1;
        chk("R1", 8'(rst_n), 8'h0);
        cyc(4);
        chk("R1", 8'(cause), 8'h0);
        // R5 / R8: release timed per domain
        tag = "R5";
        pin_n = 1'b1;
        cyc(1);
        chk("R5", 8'(rst_n[0]), 8'h0);
        cyc(1);
        chk("R8", 8'(rst_n[0]), 8'h1);
        chk("R8", 8'(rst_n[2]), 8'h0);
        cyc(12);
        chk("R5", 8'(rst_n), 8'h7);

        // R3: software bit for domain 1 only
        tag = "R3";
        sw_write(3'b010);
        chk("R3", 8'(rst_n), 8'h5);
        // R4: data without strobe is ignored, the hold remains
        tag = "R4";
        wdata = 3'b111;
        cyc(3);
        chk("R4", 8'(rst_n), 8'h5);
        wdata = '0;
        cyc(5);
        chk("R4", 8'(rst_n), 8'h5);
        sw_write(3'b000);
        cyc(6);
        chk("R4", 8'(rst_n), 8'h7);

        // R2 / R6 / R7: watchdog
        sw_write(3'b101);
        cyc(1);
        chk("R3", 8'(rst_n), 8'h2);
        tag = "R2";
        wdt = 1'b1;
        #1;
        chk("R2", 8'(rst_n), 8'h0);
        cyc(2);
        chk("R6", 8'(cause), 8'h1);
        tag = "R7";
        wdt = 1'b0;
        cyc(12);
        chk("R7", 8'(rst_n), 8'h7);
        chk("R6", 8'(cause), 8'h1);
        cyc(20);
        chk("R6", 8'(cause), 8'h1);

        // R1: pin pulse clears the cause flag
        tag = "R1";
        pin_n = 1'b0;
        cyc(2);
        chk("R1", 8'(cause), 8'h0);
        pin_n = 1'b1;
        tag = "R5";
        cyc(12);
        chk("R5", 8'(rst_n), 8'h7);

        // R7: a write in the same cycle as a watchdog request is dropped
        tag = "R7";
        wdt = 1'b1; we = 1'b1; wdata = 3'b001;
        cyc(1);
        wdt = 1'b0; we = 1'b0; wdata = '0;
        cyc(12);
        chk("R7", 8'(rst_n), 8'h7);
        chk("R6", 8'(cause), 8'h1);

        cyc(2);
        finish_run();
    end
endmodule